// File: doc/BRIEF.md
# Descriptor Chain Transfer Sequencer

This block lets one SPI message made of several transfers run with no processor action between the transfers. Software builds a table of transfer descriptors in memory. It writes the table base address into two registers and sets the pending flag in the upper one. The sequencer then reads one descriptor at a time over a simple 32-bit memory read port. It passes the control words and buffer addresses of each descriptor to the SPI engine, waits for the engine to report completion, and moves to the next descriptor in the table.

Each descriptor is 24 bytes long and is made of six 32-bit words, read in this order: start word, bus word, transmit address low, transmit address high, receive address low, receive address high. Bit 30 of the start word marks the last descriptor of a chain. The other start-word fields are passed to the engine unchanged: block count in [19:0], bytes per word in [22:20], level in [23], operation in [25:24], receive data mode in [27:26] and transmit data mode in [29:28]. The walk ends when the last descriptor completes, when a fetch returns an error, or when software aborts it. Status events are gathered in a write-one-to-clear register, and an enable mask selects which of them drive the interrupt line.

Top module: `desc_chain_seq`

## Requirements
- R1: The register offsets are 0 for base low, 1 for base high, 2 for status and 3 for interrupt enable. A write to base high with bit 31 set, made while the block is idle, starts a walk at address {high[30:0], low} truncated to ADDR_W bits. Reading base high returns the busy flag in bit 31 and the stored high bits below it. After reset the block is idle and the status register is zero.
- R2: Each descriptor is fetched as six word reads at descriptor base +0, +4, +8, +12, +16 and +20, in that order. Only one read is outstanding at a time. A request keeps mem_req and mem_addr steady until mem_rvalid returns.
- R3: Once all six words have arrived, eng_start pulses for one cycle. While it is high, eng_start_word, eng_bus_word, eng_tx_addr and eng_rx_addr carry the fetched descriptor. No fetch is issued between eng_start and eng_done.
- R4: Each eng_done sets status bit 10. The next descriptor is fetched from the previous descriptor base plus 24.
- R5: A fetched start word with bit 30 set sets status bit 0. When that descriptor's eng_done arrives, status bits 11 and 9 are set and the block becomes idle.
- R6: A read that returns with mem_rerr sets status bits 2 and 9. The chain stops and the engine is not started for that descriptor.
- R7: A write of zero to base high during a walk aborts it. The block becomes idle at once, sets status bit 9, and ignores any later eng_done. A new pending write is then accepted.
- R8: Writes to base low or base high during a walk, other than the abort, change nothing. The running chain keeps its addresses and the stored base reads back unchanged.
- R9: Writing a 1 to a status bit clears that bit. Bits written as 0 keep their value.
- R10: irq is high one cycle after any status bit that has its matching enable bit set becomes 1. It falls one cycle after no enabled status bit remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response carries an error |
| eng_start | output | 1 | One-cycle start pulse to the SPI engine |
| eng_start_word | output | 32 | Start word of the current descriptor |
| eng_bus_word | output | 32 | Bus word of the current descriptor |
| eng_tx_addr | output | ADDR_W | Transmit buffer address |
| eng_rx_addr | output | ADDR_W | Receive buffer address |
| eng_done | input | 1 | Engine finished the current transfer |

## Verification
The bench uses the default parameters: a 48-bit address and a registered interrupt output. It places the descriptor table at a base whose high register is non-zero, so every fetch address and engine address is checked in the bits above 32 as well as in the low word. The memory model answers every other cycle, which keeps each request pending across an edge. The engine model has a latency that each scenario sets: a long latency leaves room to abort during a transfer and to observe the stale completion that arrives afterwards.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

   localparam int STAT_W      = 12;
   localparam int DESC_WORDS  = 6;
   localparam int DESC_BYTES  = DESC_WORDS * 4;
   localparam int SW_LAST_BIT = 30;

   // status bit positions
   localparam int ST_RD_LAST   = 0;
   localparam int ST_RD_RESP   = 2;
   localparam int ST_READY     = 9;
   localparam int ST_DESC_DONE = 10;
   localparam int ST_CHAIN_END = 11;

   // register offsets
   localparam logic [1:0] RA_BASE_LO = 2'd0;
   localparam logic [1:0] RA_BASE_HI = 2'd1;
   localparam logic [1:0] RA_STATUS  = 2'd2;
   localparam logic [1:0] RA_IRQ_EN  = 2'd3;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_RUN   = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic [31:0] start_w;
      logic [31:0] bus_w;
      logic [63:0] tx_addr;
      logic [63:0] rx_addr;
   } xfer_desc_t;

endpackage

// File: rtl/dcs_regs.sv
module dcs_regs
   import dcs_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [1:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic [STAT_W-1:0] stat_set,
   output logic              start_req,
   output logic              abort_req,
   output logic [ADDR_W-1:0] start_base,
   output logic [STAT_W-1:0] stat_q,
   output logic              irq
);

   localparam int FULL_W = 63;

   logic [31:0]       lo_q;
   logic [30:0]       hi_q;
   logic [STAT_W-1:0] en_q;
   logic              hi_wr;
   logic              st_wr;
   logic [STAT_W-1:0] clr_mask;
   logic [FULL_W-1:0] full_base;
   logic              irq_raw;

   assign hi_wr     = reg_wr && (reg_waddr == RA_BASE_HI);
   assign st_wr     = reg_wr && (reg_waddr == RA_STATUS);
   assign start_req = hi_wr && !busy && reg_wdata[31];
   assign abort_req = hi_wr && busy && (reg_wdata == 32'd0);
   assign clr_mask  = st_wr ? reg_wdata[STAT_W-1:0] : '0;
   assign full_base = {reg_wdata[30:0], lo_q};

   generate
      if (ADDR_W < FULL_W) begin : g_trunc
         logic unused_base_hi;
         assign start_base     = full_base[ADDR_W-1:0];
         assign unused_base_hi = |full_base[FULL_W-1:ADDR_W];
      end else begin : g_full
         assign start_base = full_base;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
         en_q <= '0;
      end else if (reg_wr) begin
         if (!busy && reg_waddr == RA_BASE_LO) lo_q <= reg_wdata;
         if (!busy && reg_waddr == RA_BASE_HI) hi_q <= reg_wdata[30:0];
         if (reg_waddr == RA_IRQ_EN)           en_q <= reg_wdata[STAT_W-1:0];
      end
   end

   // a set event takes precedence over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_set | (stat_q & ~clr_mask);
   end

   assign irq_raw = |(stat_q & en_q);

   generate
      if (IRQ_REG) begin : g_irq_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= irq_raw;
         end
      end else begin : g_irq_comb
         assign irq = irq_raw;
      end
   endgenerate

   always_comb begin
      unique case (reg_raddr)
         RA_BASE_LO: reg_rdata = lo_q;
         RA_BASE_HI: reg_rdata = {busy, hi_q};
         RA_STATUS:  reg_rdata = {{(32-STAT_W){1'b0}}, stat_q};
         default:    reg_rdata = {{(32-STAT_W){1'b0}}, en_q};
      endcase
   end

endmodule

// File: rtl/dcs_fetch.sv
module dcs_fetch
   import dcs_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              kill,
   input  logic [ADDR_W-1:0] go_addr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_rerr,
   output logic              done,
   output logic              err,
   output logic              last_seen,
   output xfer_desc_t        desc
);

   localparam int IDX_W = $clog2(DESC_WORDS);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DESC_WORDS - 1);

   logic                            active;
   logic [IDX_W-1:0]                idx;
   logic [ADDR_W-1:0]               base_q;
   logic [DESC_WORDS-1:0][31:0]     words;
   logic                            take;

   assign take     = active && mem_rvalid && !kill;
   assign mem_req  = active;
   assign mem_addr = base_q + ADDR_W'({idx, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         idx       <= '0;
         base_q    <= '0;
         done      <= 1'b0;
         err       <= 1'b0;
         last_seen <= 1'b0;
      end else begin
         done      <= 1'b0;
         err       <= 1'b0;
         last_seen <= 1'b0;
         if (kill) begin
            active <= 1'b0;
         end else if (go) begin
            active <= 1'b1;
            idx    <= '0;
            base_q <= go_addr;
         end else if (take) begin
            if (mem_rerr) begin
               active <= 1'b0;
               err    <= 1'b1;
            end else begin
               if (idx == '0 && mem_rdata[SW_LAST_BIT]) last_seen <= 1'b1;
               if (idx == IDX_LAST) begin
                  active <= 1'b0;
                  done   <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
         end
      end
   end

   generate
      for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[w] <= '0;
            else if (take && !mem_rerr && idx == IDX_W'(w))
               words[w] <= mem_rdata;
         end
      end
   endgenerate

   assign desc.start_w = words[0];
   assign desc.bus_w   = words[1];
   assign desc.tx_addr = {words[3], words[2]};
   assign desc.rx_addr = {words[5], words[4]};

endmodule

// File: rtl/dcs_seq.sv
module dcs_seq
   import dcs_pkg::*;
#(
   parameter int ADDR_W = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [ADDR_W-1:0] start_base,
   input  logic              abort_req,
   input  logic              fetch_done,
   input  logic              fetch_err,
   input  logic              fetch_last,
   input  logic              desc_last,
   input  logic              eng_done,
   output logic              fetch_go,
   output logic              fetch_kill,
   output logic [ADDR_W-1:0] fetch_addr,
   output logic              busy,
   output logic              eng_start,
   output logic [STAT_W-1:0] stat_set
);

   localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

   seq_state_e        state_q, state_d;
   logic [ADDR_W-1:0] cur_q, cur_d;
   logic              start_q, start_d;

   always_comb begin
      state_d    = state_q;
      cur_d      = cur_q;
      start_d    = 1'b0;
      fetch_go   = 1'b0;
      fetch_kill = 1'b0;
      fetch_addr = start_base;
      stat_set   = '0;
      stat_set[ST_RD_LAST] = fetch_last;
      unique case (state_q)
         SQ_IDLE: begin
            if (start_req) begin
               fetch_go = 1'b1;
               cur_d    = start_base;
               state_d  = SQ_FETCH;
            end
         end
         SQ_FETCH: begin
            if (fetch_err) begin
               stat_set[ST_RD_RESP] = 1'b1;
               stat_set[ST_READY]   = 1'b1;
               state_d              = SQ_IDLE;
            end else if (fetch_done) begin
               start_d = 1'b1;
               state_d = SQ_RUN;
            end
         end
         SQ_RUN: begin
            if (eng_done) begin
               stat_set[ST_DESC_DONE] = 1'b1;
               if (desc_last) begin
                  stat_set[ST_CHAIN_END] = 1'b1;
                  stat_set[ST_READY]     = 1'b1;
                  state_d                = SQ_IDLE;
               end else begin
                  fetch_go   = 1'b1;
                  fetch_addr = cur_q + STRIDE;
                  cur_d      = cur_q + STRIDE;
                  state_d    = SQ_FETCH;
               end
            end
         end
         default: state_d = SQ_IDLE;
      endcase
      if (abort_req && state_q != SQ_IDLE) begin
         state_d            = SQ_IDLE;
         fetch_go           = 1'b0;
         fetch_kill         = 1'b1;
         start_d            = 1'b0;
         stat_set           = '0;
         stat_set[ST_READY] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         cur_q   <= '0;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cur_q   <= cur_d;
         start_q <= start_d;
      end
   end

   assign busy      = (state_q != SQ_IDLE);
   assign eng_start = start_q;

endmodule

// File: rtl/desc_chain_seq.sv
module desc_chain_seq
   import dcs_pkg::*;
#(
   parameter int ADDR_W  = 48,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [1:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_rerr,
   output logic              eng_start,
   output logic [31:0]       eng_start_word,
   output logic [31:0]       eng_bus_word,
   output logic [ADDR_W-1:0] eng_tx_addr,
   output logic [ADDR_W-1:0] eng_rx_addr,
   input  logic              eng_done
);

   generate
      if (ADDR_W < 33 || ADDR_W > 63) begin : g_bad_addr_w
         $fatal(1, "desc_chain_seq: ADDR_W must lie in 33..63");
      end
   endgenerate

   logic              busy;
   logic              start_req;
   logic              abort_req;
   logic [ADDR_W-1:0] start_base;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] stat_set;
   logic              fetch_go;
   logic              fetch_kill;
   logic [ADDR_W-1:0] fetch_addr;
   logic              fetch_done;
   logic              fetch_err;
   logic              fetch_last;
   xfer_desc_t        desc;
   logic              unused_desc_hi;

   dcs_regs #(.ADDR_W(ADDR_W), .IRQ_REG(IRQ_REG)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_waddr  (reg_waddr),
      .reg_wdata  (reg_wdata),
      .reg_raddr  (reg_raddr),
      .reg_rdata  (reg_rdata),
      .busy       (busy),
      .stat_set   (stat_set),
      .start_req  (start_req),
      .abort_req  (abort_req),
      .start_base (start_base),
      .stat_q     (stat_q),
      .irq        (irq)
   );

   dcs_fetch #(.ADDR_W(ADDR_W)) i_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (fetch_go),
      .kill       (fetch_kill),
      .go_addr    (fetch_addr),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .mem_rerr   (mem_rerr),
      .done       (fetch_done),
      .err        (fetch_err),
      .last_seen  (fetch_last),
      .desc       (desc)
   );

   dcs_seq #(.ADDR_W(ADDR_W)) i_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_req  (start_req),
      .start_base (start_base),
      .abort_req  (abort_req),
      .fetch_done (fetch_done),
      .fetch_err  (fetch_err),
      .fetch_last (fetch_last),
      .desc_last  (desc.start_w[SW_LAST_BIT]),
      .eng_done   (eng_done),
      .fetch_go   (fetch_go),
      .fetch_kill (fetch_kill),
      .fetch_addr (fetch_addr),
      .busy       (busy),
      .eng_start  (eng_start),
      .stat_set   (stat_set)
   );

   assign eng_start_word = desc.start_w;
   assign eng_bus_word   = desc.bus_w;
   assign eng_tx_addr    = desc.tx_addr[ADDR_W-1:0];
   assign eng_rx_addr    = desc.rx_addr[ADDR_W-1:0];
   assign unused_desc_hi = |{desc.tx_addr[63:ADDR_W], desc.rx_addr[63:ADDR_W]};

endmodule

// File: rtl/dcs_checker.sv
module dcs_checker #(
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              mem_rerr,
   input logic              eng_start,
   input logic              eng_done,
   input logic              reg_wr,
   input logic [1:0]        reg_waddr,
   input logic [31:0]       reg_wdata,
   input logic              chain_end
);

   logic abort_w;
   logic eng_run;

   assign abort_w = reg_wr && (reg_waddr == 2'd1) && (reg_wdata == 32'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   eng_run <= 1'b0;
      else if (abort_w || eng_done) eng_run <= 1'b0;
      else if (eng_start)           eng_run <= 1'b1;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid && !abort_w) |=> (mem_req && $stable(mem_addr))); // R2

   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start); // R3

   AST_NO_FETCH_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      eng_run |-> !mem_req); // R3

   AST_CHAIN_END_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_end) |-> $past(eng_done)); // R5

   AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_rvalid && mem_rerr && !abort_w) |=> !mem_req); // R6

   AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      abort_w |=> (!mem_req && !eng_start)); // R7

endmodule

bind desc_chain_seq dcs_checker #(.ADDR_W(ADDR_W)) i_dcs_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rvalid (mem_rvalid),
   .mem_rerr   (mem_rerr),
   .eng_start  (eng_start),
   .eng_done   (eng_done),
   .reg_wr     (reg_wr),
   .reg_waddr  (reg_waddr),
   .reg_wdata  (reg_wdata),
   .chain_end  (stat_q[11])
);

// File: tb/test_desc_chain_seq.sv
module test_desc_chain_seq;

   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 48;
   localparam logic [AW-1:0] MBASE    = 48'h00AB_0000_0100;
   localparam logic [31:0] HI_GO      = 32'h8000_00AB;
   localparam logic [31:0] LO_BASE    = 32'h0000_0100;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_waddr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [1:0]    reg_raddr = '0;
   logic [31:0]   reg_rdata;
   logic          irq;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_rvalid;
   logic [31:0]   mem_rdata;
   logic          mem_rerr;
   logic          eng_start;
   logic [31:0]   eng_start_word, eng_bus_word;
   logic [AW-1:0] eng_tx_addr, eng_rx_addr;
   logic          eng_done;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   desc_chain_seq i_desc_chain_seq (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .irq(irq),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
      .eng_start(eng_start), .eng_start_word(eng_start_word),
      .eng_bus_word(eng_bus_word), .eng_tx_addr(eng_tx_addr),
      .eng_rx_addr(eng_rx_addr), .eng_done(eng_done)
   );

   // memory model: answers a pending request at every other falling edge
   logic [31:0]   mem [0:255];
   logic          err_en = 1'b0;
   logic [AW-1:0] err_addr = '0;
   logic [AW-1:0] flog [0:127];
   int            fcnt = 0;
   logic [AW-1:0] moff;

   assign moff = mem_addr - MBASE;

   always @(negedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_rdata  <= '0;
         mem_rerr   <= 1'b0;
      end else if (mem_rvalid) begin
         mem_rvalid <= 1'b0;
         mem_rerr   <= 1'b0;
      end else if (mem_req) begin
         mem_rvalid <= 1'b1;
         mem_rdata  <= mem[moff[9:2]];
         mem_rerr   <= err_en && (mem_addr == err_addr);
         flog[fcnt] <= mem_addr;
         fcnt       <= fcnt + 1;
      end
   end

   // engine model
   int            eng_lat = 5;
   int            eng_tmr = 0;
   logic [31:0]   el_start [0:31];
   logic [31:0]   el_bus   [0:31];
   logic [AW-1:0] el_tx    [0:31];
   logic [AW-1:0] el_rx    [0:31];
   int            ecnt = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         eng_done <= 1'b0;
         eng_tmr  <= 0;
      end else begin
         eng_done <= 1'b0;
         if (eng_start) begin
            el_start[ecnt] <= eng_start_word;
            el_bus[ecnt]   <= eng_bus_word;
            el_tx[ecnt]    <= eng_tx_addr;
            el_rx[ecnt]    <= eng_rx_addr;
            ecnt           <= ecnt + 1;
            eng_tmr        <= eng_lat;
         end else if (eng_tmr != 0) begin
            eng_tmr <= eng_tmr - 1;
            if (eng_tmr == 1) eng_done <= 1'b1;
         end
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_raddr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 3000; i++) begin
         rd(2'd1, v);
         if (!v[31]) return;
      end
      check("R5 walk ends", 64'd1, 64'd0);
   endtask

   function automatic logic [31:0] sword(input int cnt, input bit last);
      return {1'b0, last, 2'd2, 2'd0, 2'd2, 1'b0, 3'd1, 20'(cnt)};
   endfunction

   task automatic put_desc(input int k, input logic [31:0] sw, input logic [31:0] bw,
                           input logic [63:0] tx, input logic [63:0] rx);
      mem[6*k+0] = sw;
      mem[6*k+1] = bw;
      mem[6*k+2] = tx[31:0];
      mem[6*k+3] = tx[63:32];
      mem[6*k+4] = rx[31:0];
      mem[6*k+5] = rx[63:32];
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(2'd2, v); check("R1 reset status", 64'(v), 64'h0);
      rd(2'd1, v); check("R1 reset idle", 64'(v), 64'h0);
      check("R1 reset mem_req", 64'(mem_req), 64'd0);
      check("R3 reset eng_start", 64'(eng_start), 64'd0);
      check("R10 reset irq", 64'(irq), 64'd0);
   endtask

   task automatic t_single();
      logic [31:0] v;
      int f0 = fcnt;
      int e0 = ecnt;
      eng_lat = 5;
      put_desc(0, sword(16, 1'b1), 32'hB0B0_0001, 64'h0000_00AB_1111_0000, 64'h0000_00AB_2222_0000);
      wr(2'd0, LO_BASE);
      wr(2'd1, HI_GO);
      rd(2'd1, v); check("R1 busy after pending", 64'(v), 64'h8000_00AB);
      wait_idle();
      check("R2 fetch count", 64'(fcnt - f0), 64'd6);
      for (int i = 0; i < 6; i++)
         check("R2 fetch addr", 64'(flog[f0+i]), 64'(MBASE + AW'(4*i)));
      check("R3 start count", 64'(ecnt - e0), 64'd1);
      check("R3 start word", 64'(el_start[e0]), 64'(sword(16, 1'b1)));
      check("R3 bus word", 64'(el_bus[e0]), 64'hB0B0_0001);
      check("R3 tx addr", 64'(el_tx[e0]), 64'h00AB_1111_0000);
      check("R3 rx addr", 64'(el_rx[e0]), 64'h00AB_2222_0000);
      rd(2'd2, v); check("R5 status after single", 64'(v), 64'hE01);
      wr(2'd2, 32'hFFF);
   endtask

   task automatic t_chain3();
      logic [31:0] v;
      int f0 = fcnt;
      int e0 = ecnt;
      eng_lat = 3;
      for (int k = 0; k < 3; k++)
         put_desc(k, sword(k+1, k == 2), 32'hC000_0000 | k,
                  64'h00AB_3000_0000 + 64'(k*256), 64'h00AB_4000_0000 + 64'(k*256));
      wr(2'd1, HI_GO);
      rd(2'd2, v); check("R4 no chain end mid walk", 64'(v[11]), 64'd0);
      wait_idle();
      check("R4 three starts", 64'(ecnt - e0), 64'd3);
      check("R2 eighteen reads", 64'(fcnt - f0), 64'd18);
      for (int i = 0; i < 18; i++)
         check("R4 stride addr", 64'(flog[f0+i]), 64'(MBASE + AW'(4*i)));
      for (int k = 0; k < 3; k++) begin
         check("R4 tx per desc", 64'(el_tx[e0+k]), 64'h00AB_3000_0000 + 64'(k*256));
         check("R4 bus per desc", 64'(el_bus[e0+k]), 64'(32'hC000_0000 | k));
      end
      rd(2'd2, v); check("R5 status after chain", 64'(v), 64'hE01);
      wr(2'd2, 32'hFFF);
   endtask

   task automatic t_fetch_err();
      logic [31:0] v;
      int f0 = fcnt;
      int e0 = ecnt;
      eng_lat = 3;
      put_desc(0, sword(1, 1'b0), 32'h1, 64'h10, 64'h20);
      put_desc(1, sword(2, 1'b0), 32'h2, 64'h30, 64'h40);
      err_addr = MBASE + AW'(24 + 12);
      err_en   = 1'b1;
      wr(2'd1, HI_GO);
      wait_idle();
      err_en = 1'b0;
      check("R6 one engine start", 64'(ecnt - e0), 64'd1);
      check("R6 reads stop at error", 64'(fcnt - f0), 64'd10);
      rd(2'd2, v); check("R6 status after error", 64'(v), 64'h604);
      repeat (10) @(negedge clk);
      check("R6 no further reads", 64'(fcnt - f0), 64'd10);
      wr(2'd2, 32'hFFF);
   endtask

   task automatic t_abort();
      logic [31:0] v;
      int e0 = ecnt;
      eng_lat = 40;
      put_desc(0, sword(4, 1'b1), 32'h7, 64'h50, 64'h60);
      wr(2'd1, HI_GO);
      for (int i = 0; i < 200 && ecnt == e0; i++) @(negedge clk);
      check("R7 engine started", 64'(ecnt - e0), 64'd1);
      wr(2'd1, 32'h0);
      rd(2'd1, v); check("R7 idle after abort", 64'(v[31]), 64'd0);
      repeat (60) @(negedge clk);
      rd(2'd2, v); check("R7 stale done ignored", 64'(v), 64'h201);
      eng_lat = 3;
      wr(2'd1, HI_GO);
      wait_idle();
      check("R7 restart runs", 64'(ecnt - e0), 64'd2);
      rd(2'd2, v); check("R7 status after restart", 64'(v), 64'hE01);
      wr(2'd2, 32'hFFF);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] v;
      int e0 = ecnt;
      eng_lat = 10;
      put_desc(0, sword(1, 1'b0), 32'h11, 64'h00AB_5000_0000, 64'h70);
      put_desc(1, sword(1, 1'b1), 32'h12, 64'h00AB_5000_0100, 64'h80);
      wr(2'd1, HI_GO);
      wr(2'd0, 32'h0000_5000);
      wr(2'd1, 32'h8000_0077);
      wait_idle();
      check("R8 two starts", 64'(ecnt - e0), 64'd2);
      check("R8 first tx kept", 64'(el_tx[e0]), 64'h00AB_5000_0000);
      check("R8 second tx kept", 64'(el_tx[e0+1]), 64'h00AB_5000_0100);
      rd(2'd0, v); check("R8 low base kept", 64'(v), 64'(LO_BASE));
      rd(2'd1, v); check("R8 high base kept", 64'(v), 64'h0000_00AB);
      rd(2'd2, v); check("R5 status after busy writes", 64'(v), 64'hE01);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      wr(2'd2, 32'h400);
      rd(2'd2, v); check("R9 one bit cleared", 64'(v), 64'hA01);
      wr(2'd2, 32'h000);
      rd(2'd2, v); check("R9 zero write keeps", 64'(v), 64'hA01);
      wr(2'd2, 32'hFFF);
      rd(2'd2, v); check("R9 all cleared", 64'(v), 64'h0);
   endtask

   task automatic t_irq();
      eng_lat = 3;
      put_desc(0, sword(2, 1'b1), 32'h21, 64'h90, 64'hA0);
      wr(2'd3, 32'h0);
      wr(2'd1, HI_GO);
      wait_idle();
      @(negedge clk);
      check("R10 masked irq low", 64'(irq), 64'd0);
      wr(2'd3, 32'h800);
      @(negedge clk);
      check("R10 enabled irq high", 64'(irq), 64'd1);
      wr(2'd2, 32'h800);
      @(negedge clk);
      check("R10 irq drops on clear", 64'(irq), 64'd0);
      wr(2'd3, 32'h001);
      @(negedge clk);
      check("R10 other bit raises irq", 64'(irq), 64'd1);
      wr(2'd2, 32'hFFF);
      @(negedge clk);
      check("R10 irq low at end", 64'(irq), 64'd0);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_chain3();
      t_fetch_err();
      t_abort();
      t_busy_ignore();
      t_w1c();
      t_irq();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule